// File: doc/BRIEF.md
# Serial Bus Bit-Clock and Frame-Sync Generator

This block makes the timing for a time-multiplexed codec serial bus. It runs from a master clock and divides it by one of eight ratios to produce a bit clock. It also produces a one-cycle clock-enable pulse on the last master cycle of every bit period. Two frame-sync strobes, one for a sound channel and one for a telecom channel, are derived from that bit clock. Each has its own programmable frame divisor. A channel's sampling rate is bit-clock / ((divisor field + 1) × 32). For example, a field of 12 on a 9.216 MHz bit clock gives about 22.15 kHz, and a field of 14 gives 19.2 kHz.

The configuration pins are plain control levels with no handshake, and the block has no data stream. A global enable starts and stops the whole bus. When it is clear, the counters restart and every output is low. Each channel also has its own enable. A new frame divisor is picked up only at that channel's next frame boundary, so no frame is ever cut short or stretched. The clock select is captured only while the bus is off.

Top module: `sfg_top`

## Requirements
- R1: The clock select `cfg_clk_sel` codes 0 to 7 give bit periods of 2, 3, 4, 5, 6, 8, 10 and 12 master cycles.
- R2: Within each bit period, `bit_clk` is high for the first floor(ratio/2) master cycles and low for the rest.
- R3: `bit_ce` is high for exactly one master cycle per bit period, on the last cycle of that period.
- R4: A channel's frame lasts (divisor field + 1) × 32 bit periods. Its frame-sync output is high for exactly the first bit period of each frame (ratio master cycles) and low otherwise.
- R5: The sound and telecom channels use their own divisor fields and count independently.
- R6: A divisor field written while a channel runs takes effect at that channel's next frame boundary. The frame in progress keeps its old length.
- R7: `cfg_clk_sel` is captured on every clock edge where `cfg_enable` is low. Changes made while the bus runs have no effect until the bus is disabled and enabled again.
- R8: While `cfg_enable` is low, all four outputs are low. On the cycle after the edge that sees `cfg_enable` high, a bit period begins. Every channel enabled at that edge starts a frame with its sync high.
- R9: A channel whose enable is low keeps its frame-sync output low. The other channel and the bit clock are unaffected.
- R10: While the synchronous reset `rst` is high, all outputs are low, whatever the configuration inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Global bus enable |
| cfg_snd_en | input | 1 | Sound channel enable |
| cfg_tel_en | input | 1 | Telecom channel enable |
| cfg_clk_sel | input | 3 | Bit-clock ratio select |
| cfg_snd_div | input | DIV_W | Sound frame divisor, count minus one |
| cfg_tel_div | input | DIV_W | Telecom frame divisor, count minus one |
| bit_clk | output | 1 | Serial bit clock |
| bit_ce | output | 1 | One-cycle pulse ending each bit period |
| snd_fsync | output | 1 | Sound frame-sync strobe |
| tel_fsync | output | 1 | Telecom frame-sync strobe |

## Verification
All outputs come straight from registers. The first cycle after the edge that sees the enable high is therefore cycle 0 of the first bit period and of every enabled channel's first frame. From then on, the bench predicts each output for cycle k from k modulo the ratio and from a bit-period count per channel. A divisor change made during cycle k is due to be seen only at the first frame wrap after it, and the bench's frame model picks up the new length at exactly that point. Samples are taken on the falling edge, one per master cycle, after every edge since enable.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  localparam int SEL_W  = 3;
  localparam int STEP_W = 4;

  // bit-period length in master cycles for each select code
  function automatic logic [STEP_W-1:0] ratio_of(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: ratio_of = 4'd2;
      3'd1: ratio_of = 4'd3;
      3'd2: ratio_of = 4'd4;
      3'd3: ratio_of = 4'd5;
      3'd4: ratio_of = 4'd6;
      3'd5: ratio_of = 4'd8;
      3'd6: ratio_of = 4'd10;
      default: ratio_of = 4'd12;
    endcase
  endfunction

  // first position of the bit-period window inside the 16-step count
  function automatic logic [STEP_W-1:0] start_of(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: start_of = 4'd7;
      3'd1: start_of = 4'd6;
      3'd2: start_of = 4'd6;
      3'd3: start_of = 4'd5;
      3'd4: start_of = 4'd5;
      3'd5: start_of = 4'd4;
      3'd6: start_of = 4'd3;
      default: start_of = 4'd2;
    endcase
  endfunction
endpackage

// File: rtl/sfg_bitclk_div.sv
module sfg_bitclk_div
  import sfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             run,
  output logic             bit_clk,
  output logic             bit_ce
);
  logic [STEP_W-1:0] step;
  logic [SEL_W-1:0]  sel_q;
  logic              run_q;
  logic [STEP_W-1:0] win_lo, win_hi, win_mid, ratio;

  always_comb begin
    ratio   = ratio_of(sel_q);
    win_lo  = start_of(sel_q);
    win_hi  = win_lo + ratio - 4'd1;
    win_mid = win_lo + (ratio >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_q <= 1'b0;
      sel_q <= sel;
      step  <= start_of(sel);
    end else begin
      run_q <= 1'b1;
      if (run_q) step <= (step == win_hi) ? win_lo : step + 4'd1;
    end
  end

  assign run     = run_q;
  assign bit_clk = run_q && (step < win_mid);
  assign bit_ce  = run_q && (step == win_hi);

  AST_STEP_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (step >= win_lo && step <= win_hi)); // R1
  AST_CE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bit_ce |=> !bit_ce); // R3
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q)) |-> $stable(sel_q)); // R7
endmodule

// File: rtl/sfg_frame_chan.sv
module sfg_frame_chan #(
  parameter int DIV_W  = 7,
  parameter int UNIT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ch_en,
  input  logic             run,
  input  logic             bit_ce,
  input  logic [DIV_W-1:0] div,
  output logic             fsync
);
  localparam int CNT_W = DIV_W + UNIT_W;

  logic             on;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] fcnt;
  logic             last, wrap;

  assign last = (fcnt == {div_q, {UNIT_W{1'b1}}});
  assign wrap = on && bit_ce && last;

  always_ff @(posedge clk) begin
    if (rst || !en || !ch_en) begin
      on    <= 1'b0;
      fcnt  <= '0;
      div_q <= div;
    end else if (!on) begin
      fcnt  <= '0;
      div_q <= div;
      if (!run || bit_ce) on <= 1'b1;
    end else if (bit_ce) begin
      if (last) begin
        fcnt  <= '0;
        div_q <= div;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  assign fsync = on && (fcnt == '0);

  AST_FS_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    fsync |-> run); // R8
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (on && $past(on) && !$past(wrap)) |-> $stable(div_q)); // R6
  AST_FS_ENDS_ON_CE: assert property (@(posedge clk) disable iff (rst)
    ($fell(fsync) && on && $past(on)) |-> $past(bit_ce)); // R4
endmodule

// File: rtl/sfg_top.sv
module sfg_top
  import sfg_pkg::*;
#(
  parameter int DIV_W      = 7,
  parameter int FRAME_UNIT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_enable,
  input  logic             cfg_snd_en,
  input  logic             cfg_tel_en,
  input  logic [SEL_W-1:0] cfg_clk_sel,
  input  logic [DIV_W-1:0] cfg_snd_div,
  input  logic [DIV_W-1:0] cfg_tel_div,
  output logic             bit_clk,
  output logic             bit_ce,
  output logic             snd_fsync,
  output logic             tel_fsync
);
  localparam int UNIT_W = $clog2(FRAME_UNIT);
  localparam int NCH    = 2;

  logic                       run;
  logic [NCH-1:0]             ch_en_v;
  logic [NCH-1:0][DIV_W-1:0]  div_v;
  logic [NCH-1:0]             fs_v;

  assign ch_en_v = {cfg_tel_en, cfg_snd_en};
  assign div_v   = {cfg_tel_div, cfg_snd_div};

  sfg_bitclk_div u_div (
    .clk(clk), .rst(rst), .en(cfg_enable), .sel(cfg_clk_sel),
    .run(run), .bit_clk(bit_clk), .bit_ce(bit_ce)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    sfg_frame_chan #(.DIV_W(DIV_W), .UNIT_W(UNIT_W)) u_chan (
      .clk(clk), .rst(rst), .en(cfg_enable), .ch_en(ch_en_v[c]),
      .run(run), .bit_ce(bit_ce), .div(div_v[c]), .fsync(fs_v[c])
    );
  end

  assign snd_fsync = fs_v[0];
  assign tel_fsync = fs_v[1];

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !(bit_clk || bit_ce || snd_fsync || tel_fsync)); // R10
  AST_CHAN_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_snd_en) |-> !snd_fsync); // R9
endmodule

// File: tb/sim_sfg_top.sv
module sim_sfg_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_enable = 1'b0, cfg_snd_en = 1'b0, cfg_tel_en = 1'b0;
  logic [2:0] cfg_clk_sel = '0;
  logic [6:0] cfg_snd_div = '0, cfg_tel_div = '0;
  logic       bit_clk, bit_ce, snd_fsync, tel_fsync;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  sfg_top u0 (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_snd_en(cfg_snd_en),
    .cfg_tel_en(cfg_tel_en), .cfg_clk_sel(cfg_clk_sel), .cfg_snd_div(cfg_snd_div),
    .cfg_tel_div(cfg_tel_div), .bit_clk(bit_clk), .bit_ce(bit_ce),
    .snd_fsync(snd_fsync), .tel_fsync(tel_fsync)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int ratio_ref(input int sel);
    return (sel < 5) ? sel + 2 : 2 * sel - 2;
  endfunction

  // enable with a config, then compare every cycle against an arithmetic model
  task automatic run_seq(input int sel, input int sd, input int td, input bit sen,
                         input bit ten, input int n, input int chg_k,
                         input int nsd, input int nsel, input string tag);
    int ratio, spos, tpos, slen, tlen, cur_sd;
    int m_bc, m_ce, m_sf, m_tf;
    @(negedge clk);
    cfg_enable = 1'b0; cfg_clk_sel = 3'(sel); cfg_snd_div = 7'(sd);
    cfg_tel_div = 7'(td); cfg_snd_en = sen; cfg_tel_en = ten;
    @(negedge clk);
    cfg_enable = 1'b1;
    ratio = ratio_ref(sel);
    spos = 0; tpos = 0; slen = 32 * (sd + 1); tlen = 32 * (td + 1); cur_sd = sd;
    m_bc = 0; m_ce = 0; m_sf = 0; m_tf = 0;
    for (int k = 0; k < n; k++) begin
      int ph;
      @(negedge clk);
      ph = k % ratio;
      if (k > 0 && ph == 0) begin
        spos++;
        if (spos == slen) begin spos = 0; slen = 32 * (cur_sd + 1); end
        tpos++;
        if (tpos == tlen) begin tpos = 0; tlen = 32 * (td + 1); end
      end
      if (bit_clk   !== (ph < ratio / 2))      m_bc++;
      if (bit_ce    !== (ph == ratio - 1))     m_ce++;
      if (snd_fsync !== (sen && spos == 0))    m_sf++;
      if (tel_fsync !== (ten && tpos == 0))    m_tf++;
      if (k == chg_k) begin
        cfg_snd_div = 7'(nsd); cur_sd = nsd; cfg_clk_sel = 3'(nsel);
      end
    end
    check(m_bc == 0, $sformatf("%s bit_clk mismatches R1 R2 sel=%0d", tag, sel), m_bc, 0);
    check(m_ce == 0, $sformatf("%s bit_ce mismatches R3 sel=%0d", tag, sel), m_ce, 0);
    check(m_sf == 0, $sformatf("%s snd_fsync mismatches R4 R5 sel=%0d", tag, sel), m_sf, 0);
    check(m_tf == 0, $sformatf("%s tel_fsync mismatches R4 R5 sel=%0d", tag, sel), m_tf, 0);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int hits;
    // R10: reset holds outputs low even with everything enabled
    cfg_enable = 1'b1; cfg_snd_en = 1'b1; cfg_tel_en = 1'b1;
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bit_clk || bit_ce || snd_fsync || tel_fsync) hits++;
    end
    check(hits == 0, "R10 outputs high during reset", hits, 0);
    @(negedge clk);
    cfg_enable = 1'b0;
    rst = 1'b0;
    // R8: global enable clear keeps everything quiet
    hits = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (bit_clk || bit_ce || snd_fsync || tel_fsync) hits++;
    end
    check(hits == 0, "R8 outputs high while bus disabled", hits, 0);
    // R1 R2 R3 R4 R5 R8: sweep every clock select
    for (int s = 0; s < 8; s++)
      run_seq(s, 0, 1, 1'b1, 1'b1, 128 * ratio_ref(s) + 10, -1, 0, s, "sweep");
    // R4 R5: realistic divisors, different per channel
    run_seq(0, 12, 14, 1'b1, 1'b1, 2000, -1, 12, 0, "rates");
    // R6 R7: divisor and select changed mid-frame
    run_seq(1, 2, 0, 1'b1, 1'b1, 700, 100, 0, 7, "R6 R7 midframe");
    // R9: telecom channel disabled
    run_seq(2, 0, 0, 1'b1, 1'b0, 600, -1, 0, 2, "R9 tel off");
    // R9: sound channel disabled
    run_seq(3, 1, 0, 1'b0, 1'b1, 800, -1, 1, 3, "R9 snd off");
    // R8: disable after running returns outputs low
    @(negedge clk);
    cfg_enable = 1'b0;
    @(negedge clk);
    hits = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (bit_clk || bit_ce || snd_fsync || tel_fsync) hits++;
    end
    check(hits == 0, "R8 outputs high after disable", hits, 0);
    finish_run();
  end
endmodule